// File: doc/BRIEF.md
# GPIO Expander Configuration Register Bank

This block holds the per-pin settings and output data of a sixteen-pin general purpose I/O expander behind a byte-wide register port with an eight-bit address. Software sets, for every pin, whether it is an input or an output, the output level, pull-up and pull-down enables, open-drain drive and logical inversion. Reading the data bytes returns the synchronized pin levels of input pins and the stored levels of output pins. The serial bus slave that issues the register accesses and the pad cells that consume the drive controls sit outside this block.

Every per-pin setting is a field of w bits. The field for pin n lives at address (base - n*w/8), at bit (n*w) mod 8. Higher-numbered pins therefore sit at lower addresses. Two-bit fields spread downward over four bytes. A separate clock-control byte lets the oscillator pin act as a plain output. Two consecutive writes of key bytes to a reset address return every register to its default value.

Top module: `gxb_cfg_bank`

## Requirements
- R1: After reset, pull-up bytes 0x06/0x07, pull-down bytes 0x08/0x09, open-drain bytes 0x0A/0x0B, inversion bytes 0x0C/0x0D, data bytes 0x10/0x11, edge-sense bytes 0x14..0x17, clock byte 0x1E and misc byte 0x1F hold 0x00. Direction bytes 0x0E/0x0F and interrupt-mask bytes 0x12/0x13 hold 0xFF. All of pin_oe, pin_out, pin_pu, pin_pd, osc_oe and osc_out are 0.
- R2: A one-bit field for pin n sits at address base-(n/8), bit n%8. The low-pin bases are pull-up 0x07, pull-down 0x09, open-drain 0x0B, inversion 0x0D, direction 0x0F, data 0x11 and interrupt mask 0x13. pin_pu and pin_pd follow their fields directly.
- R3: The two-bit edge-sense field for pin n sits at address 0x17-(n/4), bits 2*(n%4)+1 : 2*(n%4). Every sense byte reads back what was written.
- R4: A direction bit of 1 makes a pin an input with pin_oe low. A direction bit of 0 makes it an output with pin_oe high and pin_out equal to the data bit XOR the inversion bit, when open-drain is off.
- R5: For an output pin with its open-drain bit set, pin_out is 0. pin_oe is high only while the data bit XOR the inversion bit is 0.
- R6: A read of data byte 0x11 (pins 7..0) or 0x10 (pins 15..8) returns, for each input pin, pin_in XOR the inversion bit through a two-flop synchronizer. The read shows a new pin level after the second rising edge and not after the first. For each output pin, the read returns the stored data bit.
- R7: Writing 0x12 and then 0x34 to address 0x7D, with no other write in between, restores every register to its R1 value at the edge of the second write.
- R8: Any other write between the two key writes cancels the sequence, whether to another address or with another value at 0x7D. So does a 0x34 that does not directly follow a 0x12 write. A cancelled sequence leaves the registers unchanged.
- R9: In clock byte 0x1E, bit 4 drives osc_oe and bit 0 gives the level, so osc_out = bit4 AND bit0. Writing 0x1F drives the pin high and writing 0x10 drives it low.
- R10: Addresses 0x00..0x05, 0x18..0x1D and 0x20..0xFF, including 0x7D, read as 0x00. Writes to them change no register and no output.
- R11: reg_rdata follows reg_addr in the same cycle. A write with reg_we high lands at that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for one byte |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_in | input | 16 | Raw pad input levels |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin driven level |
| pin_pu | output | 16 | Per-pin pull-up enable |
| pin_pd | output | 16 | Per-pin pull-down enable |
| osc_oe | output | 1 | Oscillator pin used as output |
| osc_out | output | 1 | Oscillator pin level |

## Verification
A byte decoded at the wrong address, or a wrong bit inside a byte, shows up at once on the next read, and for the pull and direction fields on the pin outputs right after the write edge. A key detector stuck armed or stuck cancelled shows up only at the next write of 0x34. That write either wipes configuration it should have kept, or leaves configuration it should have cleared, which the next read exposes. A synchronizer of the wrong depth shifts the data read of an input pin by one cycle, and the bench catches this by reading after the first edge and again after the second.

// File: rtl/gxb_pkg.sv
`timescale 1ns/1ps
package gxb_pkg;
  localparam int PIN_COUNT  = 16;
  localparam int REG_SPAN   = 32;

  localparam int A_PULLUP   = 'h07;
  localparam int A_PULLDN   = 'h09;
  localparam int A_DRAIN    = 'h0B;
  localparam int A_INVERT   = 'h0D;
  localparam int A_DIR      = 'h0F;
  localparam int A_DATA     = 'h11;
  localparam int A_IMASK    = 'h13;
  localparam int A_SENSE    = 'h17;
  localparam int A_CLKCTL   = 'h1E;
  localparam int A_MISC     = 'h1F;
  localparam int A_SWRST    = 'h7D;

  localparam logic [7:0] SWRST_KEY1 = 8'h12;
  localparam logic [7:0] SWRST_KEY2 = 8'h34;

  // address of the byte that holds pin's field of given width
  function automatic int field_addr(int base, int pin, int width);
    return base - (pin * width) / 8;
  endfunction

  function automatic int field_bit(int pin, int width);
    return (pin * width) % 8;
  endfunction

  // flat bit position inside the byte bank
  function automatic int field_pos(int base, int pin, int width);
    return field_addr(base, pin, width) * 8 + field_bit(pin, width);
  endfunction

  function automatic logic byte_mapped(int a);
    int lo;
    lo = field_addr(A_PULLUP, PIN_COUNT - 1, 1);
    return ((a >= lo) && (a <= A_SENSE)) || (a == A_CLKCTL) || (a == A_MISC);
  endfunction

  function automatic logic [7:0] byte_reset(int a);
    int dlo;
    int mlo;
    dlo = field_addr(A_DIR, PIN_COUNT - 1, 1);
    mlo = field_addr(A_IMASK, PIN_COUNT - 1, 1);
    if (((a >= dlo) && (a <= A_DIR)) || ((a >= mlo) && (a <= A_IMASK)))
      return 8'hFF;
    return 8'h00;
  endfunction
endpackage

// File: rtl/gxb_rst_seq.sv
`timescale 1ns/1ps
module gxb_rst_seq
  import gxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       soft_rst
);
  logic armed_q;
  logic key1_hit;
  logic key2_hit;

  assign key1_hit = (addr == 8'(A_SWRST)) && (wdata == SWRST_KEY1);
  assign key2_hit = (addr == 8'(A_SWRST)) && (wdata == SWRST_KEY2);

  // every write re-decides the armed state; idle cycles keep it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (we) armed_q <= key1_hit;
  end

  assign soft_rst = we && key2_hit && armed_q;

  AST_ARM_FROM_KEY1: assert property (@(posedge clk) disable iff (!rst_n) $rose(armed_q) |-> $past(we && key1_hit)); // R7
  AST_CANCEL_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n) (we && !key1_hit) |=> !armed_q); // R8
endmodule

// File: rtl/gxb_reg_array.sv
`timescale 1ns/1ps
module gxb_reg_array
  import gxb_pkg::*;
#(
  parameter int SPAN = REG_SPAN
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              soft_rst,
  output logic [SPAN*8-1:0] bank
);
  for (genvar a = 0; a < SPAN; a++) begin : g_byte
    if (byte_mapped(a)) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= byte_reset(a);
        else if (soft_rst)                   q <= byte_reset(a);
        else if (we && (addr == 8'(a)))      q <= wdata;
      end
      assign bank[a*8 +: 8] = q;

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (we && (addr == 8'(a)) && !soft_rst) |=> (q == $past(wdata))); // R11
      AST_SOFT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (q == byte_reset(a))); // R7
    end else begin : g_hole
      assign bank[a*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/gxb_pin_ctrl.sv
`timescale 1ns/1ps
module gxb_pin_ctrl #(
  parameter int PINS  = 16,
  parameter int SYNC  = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] dir_v,
  input  logic [PINS-1:0] data_v,
  input  logic [PINS-1:0] pol_v,
  input  logic [PINS-1:0] od_v,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] rd_bits
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [SYNC-1:0] sync_q;
    logic            level;
    logic            val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC-2:0], pin_in[n]};
    end
    assign level = sync_q[SYNC-1];
    assign val   = data_v[n] ^ pol_v[n];

    assign pin_oe[n]  = !dir_v[n] && (!od_v[n] || !val);
    assign pin_out[n] = !od_v[n] && val;
    assign rd_bits[n] = dir_v[n] ? (level ^ pol_v[n]) : data_v[n];

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n) dir_v[n] |-> !pin_oe[n]); // R4
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) od_v[n] |-> !(pin_oe[n] && pin_out[n])); // R5
  end
endmodule

// File: rtl/gxb_cfg_bank.sv
`timescale 1ns/1ps
module gxb_cfg_bank
  import gxb_pkg::*;
#(
  parameter int PINS        = PIN_COUNT,
  parameter int SYNC_STAGES = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_pu,
  output logic [PINS-1:0] pin_pd,
  output logic            osc_oe,
  output logic            osc_out
);
  localparam int SPAN    = REG_SPAN;
  localparam int SPAN_AW = $clog2(SPAN);
  localparam int DBYTES  = PINS / 8;

  logic [SPAN*8-1:0] bank;
  logic              soft_rst;
  logic [PINS-1:0]   pu_v, pd_v, od_v, pol_v, dir_v, data_v, rd_bits;
  logic [7:0]        clkctl;
  logic [7:0]        rd_byte;

  gxb_rst_seq u_seq (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .soft_rst(soft_rst)
  );

  gxb_reg_array #(.SPAN(SPAN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .soft_rst(soft_rst), .bank(bank)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_fld
    assign pu_v[n]   = bank[field_pos(A_PULLUP, n, 1)];
    assign pd_v[n]   = bank[field_pos(A_PULLDN, n, 1)];
    assign od_v[n]   = bank[field_pos(A_DRAIN,  n, 1)];
    assign pol_v[n]  = bank[field_pos(A_INVERT, n, 1)];
    assign dir_v[n]  = bank[field_pos(A_DIR,    n, 1)];
    assign data_v[n] = bank[field_pos(A_DATA,   n, 1)];
  end

  gxb_pin_ctrl #(.PINS(PINS), .SYNC(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_v(dir_v),
    .data_v(data_v), .pol_v(pol_v), .od_v(od_v),
    .pin_oe(pin_oe), .pin_out(pin_out), .rd_bits(rd_bits)
  );

  assign pin_pu = pu_v;
  assign pin_pd = pd_v;

  assign clkctl  = bank[A_CLKCTL*8 +: 8];
  assign osc_oe  = clkctl[4];
  assign osc_out = clkctl[4] & clkctl[0];

  always_comb begin
    rd_byte = 8'h00;
    if (int'(reg_addr) < SPAN)
      rd_byte = bank[{reg_addr[SPAN_AW-1:0], 3'b000} +: 8];
    for (int k = 0; k < DBYTES; k++)
      if (reg_addr == 8'(A_DATA - k)) rd_byte = rd_bits[8*k +: 8];
  end
  assign reg_rdata = rd_byte;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !byte_mapped(int'(reg_addr)) |-> (reg_rdata == 8'h00)); // R10
  AST_OSC_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && (reg_addr == 8'(A_CLKCTL)) && (reg_wdata == 8'h1F)) |=> (osc_oe && osc_out)); // R9
  AST_PULL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) (reg_we && (reg_addr == 8'(A_PULLUP)) && !soft_rst) |=> (pin_pu[7:0] == $past(reg_wdata))); // R2
endmodule

// File: tb/sim_gxb_cfg_bank.sv
`timescale 1ns/1ps
module sim_gxb_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_oe, pin_out, pin_pu, pin_pd;
  logic        osc_oe, osc_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] m [0:31];
  logic       armed;

  always #2.5 clk = ~clk;

  gxb_cfg_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .pin_pd(pin_pd),
    .osc_oe(osc_oe), .osc_out(osc_out)
  );

  function automatic bit mapped(int a);
    return (a >= 6 && a <= 23) || a == 30 || a == 31;
  endfunction

  function automatic logic [7:0] rst_val(int a);
    return (a == 14 || a == 15 || a == 18 || a == 19) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [15:0] w16(int lo_addr);
    return {m[lo_addr-1], m[lo_addr]};
  endfunction

  function automatic logic [7:0] exp_rd(int a, logic [15:0] lvl);
    logic [15:0] dir, pol, dat, mix;
    dir = w16(15); pol = w16(13); dat = w16(17);
    mix = (dir & (lvl ^ pol)) | (~dir & dat);
    if (a == 17) return mix[7:0];
    if (a == 16) return mix[15:8];
    if (a < 32 && mapped(a)) return m[a];
    return 8'h00;
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] v;
    v = w16(17) ^ w16(13);
    return ~w16(15) & (~w16(11) | ~v);
  endfunction

  function automatic logic [15:0] exp_out();
    return ~w16(11) & (w16(17) ^ w16(13));
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 32; a++) m[a] = rst_val(a);
    armed = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'h7D) begin
      if (armed && d == 8'h34) model_reset();
      armed = (d == 8'h12);
    end else begin
      armed = 1'b0;
      if (a < 32 && mapped(int'(a))) m[a] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_we = 1'b0;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_pins(input string req);
    chk(req, {16'h0, pin_oe}, {16'h0, exp_oe()});
    chk(req, {16'h0, pin_out}, {16'h0, exp_out()});
    chk(req, {16'h0, pin_pu}, {16'h0, w16(7)});
    chk(req, {16'h0, pin_pd}, {16'h0, w16(9)});
    chk(req, {30'h0, osc_oe, osc_out}, {30'h0, m[30][4], m[30][4] & m[30][0]});
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'h0, d}, {24'h0, exp_rd(int'(a), pin_in)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h0C0FFEE5));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset image over the whole mapped range
    for (int a = 0; a < 32; a++) chk_rd("R1", 8'(a));
    chk_pins("R1");
    chk({16'h0, pin_oe} == 0 ? "R1" : "R1 oe", {16'h0, pin_oe}, 32'h0);

    // R2 descending byte order of one-bit fields
    wr(8'h07, 8'h01); wr(8'h06, 8'h80);
    chk("R2 pull-up", {16'h0, pin_pu}, 32'h8001);
    wr(8'h09, 8'h02);
    chk("R2 pull-down", {16'h0, pin_pd}, 32'h0002);
    chk_rd("R2", 8'h06);

    // R3 two-bit sense fields spread over four bytes
    wr(8'h14, 8'hC0); wr(8'h17, 8'h03);
    rd(8'h14, d); chk("R3 pin15 field", {24'h0, d}, 32'hC0);
    rd(8'h17, d); chk("R3 pin0 field", {24'h0, d}, 32'h03);

    // R4 direction and push-pull drive with inversion
    wr(8'h11, 8'h05); wr(8'h0F, 8'hFA);
    chk("R4 oe", {16'h0, pin_oe}, 32'h0005);
    chk("R4 out", {16'h0, pin_out}, 32'h0005);
    wr(8'h0D, 8'h01);
    chk("R4 invert", {16'h0, pin_out}, 32'h0004);

    // R5 open-drain releases a high level
    wr(8'h0B, 8'h04);
    chk("R5 release", {16'h0, pin_oe}, 32'h0001);
    chk("R5 out", {16'h0, pin_out}, 32'h0000);
    wr(8'h11, 8'h01);
    chk("R5 pull low", {16'h0, pin_oe}, 32'h0005);
    chk_pins("R5");

    // R6 input path through two flops; output pins read stored data
    @(negedge clk); pin_in = 16'hA50F;
    repeat (3) @(negedge clk);
    chk_rd("R6", 8'h11);
    chk_rd("R6", 8'h10);
    pin_in = 16'h5A0F;
    @(negedge clk);
    rd(8'h10, d); chk("R6 one edge", {24'h0, d}, 32'hA5);
    @(negedge clk);
    rd(8'h10, d); chk("R6 two edges", {24'h0, d}, 32'h5A);

    // R8 cancellations keep registers
    wr(8'h07, 8'h55);
    wr(8'h7D, 8'h12); wr(8'h20, 8'h00); wr(8'h7D, 8'h34);
    rd(8'h07, d); chk("R8 other address", {24'h0, d}, 32'h55);
    wr(8'h7D, 8'h12); wr(8'h7D, 8'h13); wr(8'h7D, 8'h34);
    rd(8'h07, d); chk("R8 other value", {24'h0, d}, 32'h55);
    wr(8'h7D, 8'h34);
    rd(8'h0F, d); chk("R8 lone key", {24'h0, d}, 32'hFA);

    // R9 oscillator pin as output
    wr(8'h1E, 8'h1F);
    chk("R9 high", {30'h0, osc_oe, osc_out}, 32'h3);
    wr(8'h1E, 8'h10);
    chk("R9 low", {30'h0, osc_oe, osc_out}, 32'h2);
    rd(8'h1E, d); chk("R9 readback", {24'h0, d}, 32'h10);

    // R10 holes read zero and ignore writes
    wr(8'h05, 8'hFF); rd(8'h05, d); chk("R10 0x05", {24'h0, d}, 32'h0);
    wr(8'h19, 8'hFF); rd(8'h19, d); chk("R10 0x19", {24'h0, d}, 32'h0);
    wr(8'h40, 8'hFF); rd(8'h40, d); chk("R10 0x40", {24'h0, d}, 32'h0);
    rd(8'h7D, d); chk("R10 0x7D", {24'h0, d}, 32'h0);
    chk_pins("R10");

    // R7 full key sequence restores defaults
    wr(8'h7D, 8'h12); wr(8'h7D, 8'h34);
    rd(8'h07, d); chk("R7 pull-up", {24'h0, d}, 32'h00);
    rd(8'h0F, d); chk("R7 direction", {24'h0, d}, 32'hFF);
    rd(8'h14, d); chk("R7 sense", {24'h0, d}, 32'h00);
    chk("R7 oe", {16'h0, pin_oe}, 32'h0);
    chk_pins("R7");

    // R11 random traffic against the bench model
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      @(negedge clk); pin_in = 16'($urandom);
      if ($urandom % 8 == 0) begin
        wr(8'h7D, 8'h12);
        wr(8'h7D, ($urandom % 2 == 0) ? 8'h34 : 8'($urandom));
      end else begin
        wr(8'($urandom % 34), 8'($urandom));
      end
      repeat (2) @(negedge clk);
      a = ($urandom % 4 == 0) ? 8'(16 + $urandom % 2) : 8'($urandom % 34);
      chk_rd("R11", a);
      chk_pins("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule